// File: doc/BRIEF.md
# Mode-Switched Interrupt Priority Router

The router gathers level-sensitive interrupt requests from five sources: a primary timer/IO controller, a secondary IO controller, an Ethernet controller, a serial controller and a non-maskable source. Each request is mapped to a CPU priority level. The routing-mode input selects the mapping table. The routed requests are held in an 8-bit pending register. Bit i of that register stands for priority level i+1. From the pending register the block drives a 3-bit interrupt priority level and an 8-bit autovector number to a 68k-style CPU.

In classic routing, the Ethernet request never reaches the pending register. Its level is forwarded on a dedicated line that feeds a slot input of the secondary IO controller. A one-cycle NMI trigger is stretched: it holds the level-7 pending bit for a fixed number of clock cycles and then clears it.

Request lines are sampled once. The block then acts on the changes between successive samples. Routing is therefore applied at the moment a line changes and is never revisited afterwards.

Top module: `irq_prio_router`

## Requirements
- R1: With the stored mode high (classic), a change on req_i bit 0 (primary IO) sets or clears the level-1 pending bit, bit 1 (secondary IO) level 2, bit 3 (serial) level 4 and bit 4 (non-maskable) level 7.
- R2: With the stored mode low (alternate), req_i bit 0 maps to level 6, bit 1 to level 2, bit 2 (Ethernet) to level 3, bit 3 to level 4 and bit 4 to level 7.
- R3: In classic mode, an Ethernet change leaves the pending register untouched and copies the new level to eth_bypass_o. eth_bypass_o changes only because of an Ethernet change made in classic mode, and it changes on the second rising clock edge after req_i changes.
- R4: A rising request sets its pending bit and a falling request clears it. ipl_o shows the highest level whose pending bit is set, whatever other levels are also pending. Pending bit 7 is never set.
- R5: vector_o equals ipl_o plus 24 whenever ipl_o is non-zero, and equals 0 when no bit is pending.
- R6: ipl_o and vector_o change on the third rising clock edge after a req_i change.
- R7: A one-cycle pulse on nmi_trig_i sets the level-7 pending bit, so ipl_o reads 7 from the third rising edge after the pulse. The bit clears NMI_HOLD cycles later, with no further input.
- R8: A new nmi_trig_i pulse while the hold count is running restarts the full NMI_HOLD count.
- R9: A change on mode_i alone does not move bits that are already pending. A later request change follows the new mapping, even when it falls on a line that was set under the old mapping.
- R10: Asserting rst_ni low clears the pending register, eth_bypass_o, ipl_o and vector_o. It resets the stored mode to alternate and cancels a running NMI hold, so the hold's level stays cleared after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Routing mode: 1 selects classic, 0 selects alternate |
| req_i | input | 5 | Request levels: [0] primary IO, [1] secondary IO, [2] Ethernet, [3] serial, [4] non-maskable |
| nmi_trig_i | input | 1 | One-cycle NMI trigger; the level-7 bit is held for NMI_HOLD cycles |
| ipl_o | output | 3 | Highest pending priority level, 0 when idle |
| vector_o | output | 8 | Autovector number (level + 24), 0 when idle |
| eth_bypass_o | output | 1 | Ethernet level forwarded in classic mode |

## Verification
The hardest state to reach is a pending bit stranded by a mode change. A line is asserted under one mapping, the mode flips, and the line then drops under the other mapping. Its deassertion then clears a different bit and leaves the original level showing. The vector table walks exactly this sequence for the primary IO line and for Ethernet. It then re-asserts and drops the line under the original mode to recover. Retriggering the NMI stretcher partway through its hold, and resetting while a hold is running, are done as directed tests with a shortened hold parameter.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int N_SRC    = 5;
  localparam int SRC_IO1  = 0;
  localparam int SRC_IO2  = 1;
  localparam int SRC_ETH  = 2;
  localparam int SRC_SER  = 3;
  localparam int SRC_NMI  = 4;
  localparam int N_PEND   = 8;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 24;
  localparam int NMI_BIT  = 6;

  typedef logic [N_PEND-1:0] pend_t;

  // pending-bit index for a source; -1 = not routed to pending register
  function automatic int route_bit(input int src, input logic classic);
    int b;
    b = -1;
    if (classic) begin
      case (src)
        SRC_IO1: b = 0;
        SRC_IO2: b = 1;
        SRC_SER: b = 3;
        SRC_NMI: b = NMI_BIT;
        default: b = -1;
      endcase
    end else begin
      case (src)
        SRC_IO1: b = 5;
        SRC_IO2: b = 1;
        SRC_ETH: b = 2;
        SRC_SER: b = 3;
        SRC_NMI: b = NMI_BIT;
        default: b = -1;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/irq_req_sampler.sv
module irq_req_sampler #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] samp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      samp_q <= lvl_i;
      prev_q <= samp_q;
    end
  end

  assign rise_o = samp_q & ~prev_q;
  assign fall_o = ~samp_q & prev_q;
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
  import irq_route_pkg::*;
(
  input  logic             classic_i,
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] fall_i,
  output pend_t            set_o,
  output pend_t            clr_o,
  output logic             eth_byp_rise_o,
  output logic             eth_byp_fall_o
);
  logic [N_SRC-1:0][N_PEND-1:0] tgt_cls, tgt_alt, tgt;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar b = 0; b < N_PEND; b++) begin : g_bit
      assign tgt_cls[s][b] = (route_bit(s, 1'b1) == b);
      assign tgt_alt[s][b] = (route_bit(s, 1'b0) == b);
    end
    assign tgt[s] = classic_i ? tgt_cls[s] : tgt_alt[s];
  end

  always_comb begin
    set_o = '0;
    clr_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (rise_i[s]) set_o |= tgt[s];
      if (fall_i[s]) clr_o |= tgt[s];
    end
  end

  assign eth_byp_rise_o = classic_i & rise_i[SRC_ETH];
  assign eth_byp_fall_o = classic_i & fall_i[SRC_ETH];
endmodule

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
  parameter int HOLD = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o,
  output logic active_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign expire_o = (cnt_q == CW'(1)) && !start_i;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_route_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pend_t            pend_i,
  output logic [LVL_W-1:0] ipl_o,
  output logic [VEC_W-1:0] vector_o
);
  localparam int MAX_LVL = (1 << LVL_W) - 1;

  logic [LVL_W-1:0] lvl_d;

  always_comb begin
    lvl_d = '0;
    for (int i = 0; i < N_PEND; i++) begin
      if (pend_i[i]) lvl_d = (i + 1 > MAX_LVL) ? LVL_W'(MAX_LVL) : LVL_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_o    <= '0;
      vector_o <= '0;
    end else begin
      ipl_o    <= lvl_d;
      vector_o <= (lvl_d == '0) ? '0 : VEC_W'(VEC_BASE) + VEC_W'(lvl_d);
    end
  end
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_route_pkg::*;
#(
  parameter int NMI_HOLD = 12_500_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic             nmi_trig_i,
  output logic [LVL_W-1:0] ipl_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             eth_bypass_o
);
  localparam int SW = N_SRC + 1;

  logic [SW-1:0]    rise, fall;
  logic             mode_q;
  pend_t            pend_q, pend_d, set_m, clr_m;
  logic             byp_rise, byp_fall, byp_q;
  logic             nmi_start, nmi_expire, nmi_active;

  irq_req_sampler #(.W(SW)) u_samp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({nmi_trig_i, req_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  // mode captured alongside the request sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end

  irq_route_map u_map (
    .classic_i      (mode_q),
    .rise_i         (rise[N_SRC-1:0]),
    .fall_i         (fall[N_SRC-1:0]),
    .set_o          (set_m),
    .clr_o          (clr_m),
    .eth_byp_rise_o (byp_rise),
    .eth_byp_fall_o (byp_fall)
  );

  assign nmi_start = rise[N_SRC];

  irq_nmi_stretch #(.HOLD(NMI_HOLD)) u_nmi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (nmi_start),
    .expire_o (nmi_expire),
    .active_o (nmi_active)
  );

  always_comb begin
    pend_d = (pend_q | set_m) & ~clr_m;
    if (nmi_start)       pend_d[NMI_BIT] = 1'b1;
    else if (nmi_expire) pend_d[NMI_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      byp_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (byp_rise)      byp_q <= 1'b1;
      else if (byp_fall) byp_q <= 1'b0;
    end
  end

  assign eth_bypass_o = byp_q;

  irq_prio_enc u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend_q),
    .ipl_o    (ipl_o),
    .vector_o (vector_o)
  );
endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk
  import irq_route_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_q,
  input logic             eth_edge,
  input logic             nmi_start,
  input pend_t            pend_q,
  input logic [LVL_W-1:0] ipl_o,
  input logic [VEC_W-1:0] vector_o,
  input logic             eth_bypass_o
);
  assert_vec_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o == ((ipl_o == '0) ? VEC_W'(0) : VEC_W'(VEC_BASE) + VEC_W'(ipl_o)));

  assert_nmi_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_start |=> ##1 (ipl_o == LVL_W'(7)));

  assert_eth_skip_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && eth_edge) |=> (pend_q[2] == $past(pend_q[2])));

  assert_byp_only_classic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(eth_bypass_o) |-> $past(mode_q));

  assert_top_bit_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[N_PEND-1]);
endmodule

bind irq_prio_router irq_prio_router_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_q       (mode_q),
  .eth_edge     (rise[2] | fall[2]),
  .nmi_start    (nmi_start),
  .pend_q       (pend_q),
  .ipl_o        (ipl_o),
  .vector_o     (vector_o),
  .eth_bypass_o (eth_bypass_o)
);

// File: tb/irq_prio_router_test.sv
module irq_prio_router_test;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic [4:0] req_i = '0;
  logic       nmi_trig_i = 1'b0;
  logic [2:0] ipl_o;
  logic [7:0] vector_o;
  logic       eth_bypass_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_prio_router #(.NMI_HOLD(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i),
    .nmi_trig_i(nmi_trig_i), .ipl_o(ipl_o), .vector_o(vector_o),
    .eth_bypass_o(eth_bypass_o)
  );

  // {mode, req[4:0], ipl[2:0], bypass}
  localparam int NV = 26;
  localparam logic [9:0] TBL [NV] = '{
    {1'b0, 5'b00001, 3'd6, 1'b0}, // R2 io1
    {1'b0, 5'b00000, 3'd0, 1'b0},
    {1'b0, 5'b00010, 3'd2, 1'b0}, // R2 io2
    {1'b0, 5'b00110, 3'd3, 1'b0}, // R2 eth, R4
    {1'b0, 5'b01110, 3'd4, 1'b0}, // R2 ser
    {1'b0, 5'b11110, 3'd7, 1'b0}, // R2 nmi
    {1'b0, 5'b01110, 3'd4, 1'b0}, // R4 clear top
    {1'b0, 5'b00000, 3'd0, 1'b0},
    {1'b1, 5'b00000, 3'd0, 1'b0},
    {1'b1, 5'b00001, 3'd1, 1'b0}, // R1 io1
    {1'b1, 5'b00011, 3'd2, 1'b0}, // R1 io2
    {1'b1, 5'b00111, 3'd2, 1'b1}, // R3 bypass
    {1'b1, 5'b01111, 3'd4, 1'b1}, // R1 ser
    {1'b1, 5'b11111, 3'd7, 1'b1}, // R1 nmi
    {1'b1, 5'b00000, 3'd0, 1'b0},
    {1'b0, 5'b00001, 3'd6, 1'b0}, // R9 sequence
    {1'b1, 5'b00001, 3'd6, 1'b0},
    {1'b1, 5'b00000, 3'd6, 1'b0},
    {1'b0, 5'b00000, 3'd6, 1'b0},
    {1'b0, 5'b00001, 3'd6, 1'b0},
    {1'b0, 5'b00000, 3'd0, 1'b0},
    {1'b0, 5'b00100, 3'd3, 1'b0}, // R9 eth
    {1'b1, 5'b00100, 3'd3, 1'b0},
    {1'b1, 5'b00000, 3'd3, 1'b0},
    {1'b0, 5'b00100, 3'd3, 1'b0},
    {1'b0, 5'b00000, 3'd0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int exp_ipl, input int exp_byp);
    chk(req, ipl_o, exp_ipl);
    chk({req, "/R5"}, vector_o, (exp_ipl == 0) ? 0 : exp_ipl + 24);
    chk(req, eth_bypass_o, exp_byp);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trig();
    @(negedge clk);
    nmi_trig_i = 1'b1;
    @(negedge clk);
    nmi_trig_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    edges(2);
    chk_out("R10 reset", 0, 0);
    rst_ni = 1'b1;
    edges(2);
    chk_out("R10 idle", 0, 0);

    for (int i = 0; i < NV; i++) begin
      mode_i = TBL[i][9];
      req_i  = TBL[i][8:4];
      edges(3);
      chk_out($sformatf("R4 vec%0d", i), int'(TBL[i][3:1]), int'(TBL[i][0]));
    end

    // R6 and R3 latency
    mode_i = 1'b0; req_i = 5'b00010;
    edges(2);
    chk("R6 early", ipl_o, 0);
    edges(1);
    chk("R6 on time", ipl_o, 2);
    req_i = 5'b00000;
    edges(3);
    mode_i = 1'b1;
    edges(1);
    req_i = 5'b00100;
    edges(1);
    chk("R3 early", eth_bypass_o, 0);
    edges(1);
    chk("R3 on time", eth_bypass_o, 1);
    chk("R3 no pend", ipl_o, 0);
    req_i = 5'b00000;
    edges(3);
    chk("R3 drop", eth_bypass_o, 0);
    mode_i = 1'b0;
    edges(2);

    // R7 stretch
    trig();
    edges(2);
    chk("R7 set", ipl_o, 7);
    chk("R7 vec", vector_o, 31);
    edges(HOLD - 1);
    chk("R7 held", ipl_o, 7);
    edges(1);
    chk("R7 expire", ipl_o, 0);

    // R8 retrigger
    trig();
    edges(2 + 20);
    trig();
    edges(2);
    chk("R8 re-set", ipl_o, 7);
    edges(HOLD - 1);
    chk("R8 extended", ipl_o, 7);
    edges(1);
    chk("R8 expire", ipl_o, 0);

    // R10 reset mid-hold
    mode_i = 1'b1;
    req_i = 5'b01011;
    trig();
    edges(4);
    chk("R10 pre", ipl_o, 7);
    req_i = 5'b00000;
    rst_ni = 1'b0;
    #1;
    chk_out("R10 async", 0, 0);
    edges(2);
    rst_ni = 1'b1;
    mode_i = 1'b0;
    edges(HOLD + 4);
    chk_out("R10 hold cancelled", 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule